// File: doc/BRIEF.md
# Aging-Counter Page Victim Selector

This block tracks recent use of N physical memory frames and names one of them as the frame to evict. Each frame has a single use flag and an 8-bit usage history. A memory access sets the use flag of the frame it touches. A periodic aging pulse moves every use flag into the top bit of its frame's history, pushing the older bits one place down, and then clears the flag. Recently used frames therefore carry large history values, and idle frames decay toward zero.

When a selection is requested, a sequential search visits one frame per cycle. It keeps the frame with the smallest history value read as an unsigned number. On equal history a clean frame wins over a modified one, because evicting a modified frame costs a writeback. Any remaining tie goes to the lowest frame number. Frames marked as pinned are skipped. If every frame is pinned, the result says that no victim exists.

Requests use a valid/ready pair. The block takes a request only while idle. The result is presented with a valid flag and stays stable until the consumer raises ready, so the consumer can apply back-pressure for any number of cycles. Generating the aging pulse and moving the page data are the job of surrounding logic.

Top module: `page_age_victim`

## Requirements
- R1: After reset every history value and every use flag is zero, `req_ready` is 1 and `res_valid` is 0.
- R2: A cycle with `acc_valid` high sets the use flag of frame `acc_frame`.
- R3: On a cycle with `tick` high, each frame's history becomes {use flag, history[7:1]}: the flag enters bit 7 (the MSB), bit 0, the oldest, is discarded, and the use flag is cleared.
- R4: An access in the same cycle as `tick` leaves that frame's use flag set after the clear, so the access counts at the next tick.
- R5: The selected frame is the non-pinned frame with the smallest history value, compared as unsigned.
- R6: Among frames with equal smallest history, a frame whose `frame_dirty` bit is 0 is chosen over one whose bit is 1.
- R7: Any tie left after R5 and R6 goes to the lowest frame index.
- R8: A frame whose `frame_lock` bit is 1 is never selected. If all bits of `frame_lock` are 1, the result has `res_none`=1, `res_frame`=0 and `res_dirty`=0.
- R9: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while idle. `res_valid` rises N clock edges after the accepting edge. It holds with stable `res_frame`, `res_dirty` and `res_none` until an edge with `res_ready` 1, and after that edge the block is idle again.
- R10: `res_dirty` equals the `frame_dirty` bit of the selected frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Aging pulse, one cycle per period |
| acc_valid | input | 1 | A memory access touches a frame this cycle |
| acc_frame | input | IDX_W | Frame index of the access |
| frame_dirty | input | N_FRAMES | Per-frame modified flags, held stable during a search |
| frame_lock | input | N_FRAMES | Per-frame pinned flags, held stable during a search |
| req_valid | input | 1 | Selection request |
| req_ready | output | 1 | Block is idle and accepts a request |
| res_valid | output | 1 | Selection result is present |
| res_ready | input | 1 | Consumer takes the result |
| res_frame | output | IDX_W | Selected frame index |
| res_dirty | output | 1 | Modified flag of the selected frame |
| res_none | output | 1 | No selectable frame exists |

## Verification
The hardest cases to reach are those that depend on history contents, because those values cannot be loaded directly. The only way to set them is through sequences of accesses and aging pulses. The stimulus builds a known history for each frame by touching selected frames between pulses. It then chooses pin and modified masks so that the candidate set is narrowed to exactly the frames whose order matters. One case checks that the oldest bit drops out. Another checks that an access arriving with a pulse still counts. A third holds back the result consumer for several cycles while the result must stay put.

// File: rtl/pav_pkg.sv
package pav_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SCAN = 2'd1,
    S_DONE = 2'd2
  } scan_state_t;
endpackage

// File: rtl/pav_frame_bank.sv
// Per-frame use flag and aging history (R2, R3, R4).
module pav_frame_bank #(
  parameter int N_FRAMES = 8,
  parameter int HIST_W   = 8,
  localparam int IDX_W   = $clog2(N_FRAMES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       acc_valid,
  input  logic [IDX_W-1:0]           acc_frame,
  output logic [N_FRAMES*HIST_W-1:0] hist_flat,
  output logic [N_FRAMES-1:0]        use_vec
);
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
    logic              hit;
    logic              use_q;
    logic [HIST_W-1:0] hist_q;

    assign hit = acc_valid && (acc_frame == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        use_q  <= 1'b0;
        hist_q <= '0;
      end else if (tick) begin
        hist_q <= {use_q, hist_q[HIST_W-1:1]};
        use_q  <= hit;             // access during the pulse survives the clear
      end else if (hit) begin
        use_q  <= 1'b1;
      end
    end

    assign hist_flat[g*HIST_W +: HIST_W] = hist_q;
    assign use_vec[g]                    = use_q;
  end
endmodule

// File: rtl/pav_scanner.sv
// Sequential minimum search, one frame per cycle (R5..R10).
module pav_scanner
  import pav_pkg::*;
#(
  parameter int N_FRAMES = 8,
  parameter int HIST_W   = 8,
  localparam int IDX_W   = $clog2(N_FRAMES),
  localparam int KEY_W   = HIST_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_FRAMES*HIST_W-1:0] hist_flat,
  input  logic [N_FRAMES-1:0]        frame_dirty,
  input  logic [N_FRAMES-1:0]        frame_lock,
  input  logic                       req_valid,
  output logic                       req_ready,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [IDX_W-1:0]           res_frame,
  output logic                       res_dirty,
  output logic                       res_none
);
  scan_state_t       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              best_ok_q;
  logic [KEY_W-1:0]  best_key_q;
  logic [IDX_W-1:0]  best_idx_q;
  logic              best_dirty_q;

  logic [HIST_W-1:0] cur_hist;
  logic [KEY_W-1:0]  cur_key;
  logic              take;
  logic              nb_ok;
  logic [KEY_W-1:0]  nb_key;
  logic [IDX_W-1:0]  nb_idx;
  logic              nb_dirty;

  // key orders by history first, then clean before dirty; strict less keeps lowest index
  assign cur_hist = hist_flat[int'(idx_q)*HIST_W +: HIST_W];
  assign cur_key  = {cur_hist, frame_dirty[idx_q]};
  assign take     = !frame_lock[idx_q] && (!best_ok_q || (cur_key < best_key_q));

  always_comb begin
    nb_ok    = best_ok_q;
    nb_key   = best_key_q;
    nb_idx   = best_idx_q;
    nb_dirty = best_dirty_q;
    if (take) begin
      nb_ok    = 1'b1;
      nb_key   = cur_key;
      nb_idx   = idx_q;
      nb_dirty = frame_dirty[idx_q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      idx_q        <= '0;
      best_ok_q    <= 1'b0;
      best_key_q   <= '0;
      best_idx_q   <= '0;
      best_dirty_q <= 1'b0;
      res_frame    <= '0;
      res_dirty    <= 1'b0;
      res_none     <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          state_q      <= S_SCAN;
          idx_q        <= '0;
          best_ok_q    <= 1'b0;
          best_key_q   <= '0;
          best_idx_q   <= '0;
          best_dirty_q <= 1'b0;
        end
        S_SCAN: begin
          best_ok_q    <= nb_ok;
          best_key_q   <= nb_key;
          best_idx_q   <= nb_idx;
          best_dirty_q <= nb_dirty;
          idx_q        <= idx_q + IDX_W'(1);
          if (idx_q == IDX_W'(N_FRAMES - 1)) begin
            state_q   <= S_DONE;
            res_frame <= nb_idx;
            res_dirty <= nb_dirty;
            res_none  <= !nb_ok;
          end
        end
        S_DONE: if (res_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == S_IDLE);
  assign res_valid = (state_q == S_DONE);
endmodule

// File: rtl/page_age_victim.sv
module page_age_victim #(
  parameter int N_FRAMES = 8,
  parameter int HIST_W   = 8,
  localparam int IDX_W   = $clog2(N_FRAMES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                acc_valid,
  input  logic [IDX_W-1:0]    acc_frame,
  input  logic [N_FRAMES-1:0] frame_dirty,
  input  logic [N_FRAMES-1:0] frame_lock,
  input  logic                req_valid,
  output logic                req_ready,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [IDX_W-1:0]    res_frame,
  output logic                res_dirty,
  output logic                res_none
);
  logic [N_FRAMES*HIST_W-1:0] hist_flat;
  logic [N_FRAMES-1:0]        use_vec;

  pav_frame_bank #(.N_FRAMES(N_FRAMES), .HIST_W(HIST_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .hist_flat (hist_flat),
    .use_vec   (use_vec)
  );

  pav_scanner #(.N_FRAMES(N_FRAMES), .HIST_W(HIST_W)) u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .hist_flat   (hist_flat),
    .frame_dirty (frame_dirty),
    .frame_lock  (frame_lock),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .res_valid   (res_valid),
    .res_ready   (res_ready),
    .res_frame   (res_frame),
    .res_dirty   (res_dirty),
    .res_none    (res_none)
  );
endmodule

// File: rtl/pav_checker.sv
module pav_checker #(
  parameter int N_FRAMES = 8,
  parameter int HIST_W   = 8,
  localparam int IDX_W   = $clog2(N_FRAMES)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       acc_valid,
  input logic [IDX_W-1:0]           acc_frame,
  input logic                       req_ready,
  input logic                       res_valid,
  input logic                       res_ready,
  input logic [IDX_W-1:0]           res_frame,
  input logic                       res_dirty,
  input logic                       res_none,
  input logic [N_FRAMES*HIST_W-1:0] hist_flat,
  input logic [N_FRAMES-1:0]        use_vec
);
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_chk
    a_r3_flag_to_msb: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick) |-> hist_flat[g*HIST_W + HIST_W - 1] == $past(use_vec[g]));
    a_r3_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tick) |-> hist_flat[g*HIST_W +: HIST_W-1] == $past(hist_flat[g*HIST_W+1 +: HIST_W-1]));
  end

  a_r2_access_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && !tick) |-> use_vec[$past(acc_frame)]);

  a_r4_access_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && tick) |-> use_vec[$past(acc_frame)]);

  a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_frame) && $stable(res_dirty) && $stable(res_none));

  a_r9_idle_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  a_r8_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_none |-> (res_frame == '0) && !res_dirty);
endmodule

bind page_age_victim pav_checker #(.N_FRAMES(N_FRAMES), .HIST_W(HIST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .acc_valid (acc_valid),
  .acc_frame (acc_frame),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_frame (res_frame),
  .res_dirty (res_dirty),
  .res_none  (res_none),
  .hist_flat (hist_flat),
  .use_vec   (use_vec)
);

// File: tb/page_age_victim_bench.sv
module page_age_victim_bench;
  localparam int N  = 8;
  localparam int HW = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          acc_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic [N-1:0]  frame_dirty = '0;
  logic [N-1:0]  frame_lock = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [IW-1:0] res_frame;
  logic          res_dirty;
  logic          res_none;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  page_age_victim #(.N_FRAMES(N), .HIST_W(HW)) u_page_age_victim (
    .clk(clk), .rst_n(rst_n), .tick(tick), .acc_valid(acc_valid), .acc_frame(acc_frame),
    .frame_dirty(frame_dirty), .frame_lock(frame_lock), .req_valid(req_valid),
    .req_ready(req_ready), .res_valid(res_valid), .res_ready(res_ready),
    .res_frame(res_frame), .res_dirty(res_dirty), .res_none(res_none));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_hist[N];
  int m_use[N];
  int m_state = 0;   // 0 idle, 1 searching, 2 result
  int m_cnt = 0;
  int m_frame = 0;
  int m_dirty = 0;
  int m_none = 0;

  function automatic void m_pick();
    int best = -1;
    for (int f = 0; f < N; f++) begin
      if (!frame_lock[f]) begin
        if (best < 0) best = f;
        else if (m_hist[f] < m_hist[best]) best = f;
        else if (m_hist[f] == m_hist[best] && !frame_dirty[f] && frame_dirty[best]) best = f;
      end
    end
    m_none  = (best < 0);
    m_frame = (best < 0) ? 0 : best;
    m_dirty = (best < 0) ? 0 : int'(frame_dirty[best]);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int f = 0; f < N; f++) begin m_hist[f] = 0; m_use[f] = 0; end
      m_state = 0; m_cnt = 0;
    end else begin
      if (tick) begin
        for (int f = 0; f < N; f++) begin
          m_hist[f] = (m_use[f] * (1 << (HW - 1))) + (m_hist[f] / 2);
          m_use[f]  = 0;
        end
      end
      if (acc_valid) m_use[acc_frame] = 1;
      if (m_state == 0 && req_valid) begin
        m_state = 1; m_cnt = 0;
      end else if (m_state == 1) begin
        m_cnt++;
        if (m_cnt == N) begin m_state = 2; m_pick(); end
      end else if (m_state == 2 && res_ready) begin
        m_state = 0;
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(req_ready == (m_state == 0), "R9 req_ready", req_ready, m_state == 0);
      chk(res_valid == (m_state == 2), "R9 res_valid", res_valid, m_state == 2);
      if (res_valid && m_state == 2) begin
        chk(res_frame == m_frame, "R5 model frame", res_frame, m_frame);
        chk(res_dirty == m_dirty, "R10 model dirty", res_dirty, m_dirty);
        chk(res_none == m_none, "R8 model none", res_none, m_none);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic touch(input int f);
    @(negedge clk); acc_valid = 1'b1; acc_frame = IW'(f);
    @(negedge clk); acc_valid = 1'b0;
  endtask

  task automatic age(input int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic age_with_touch(input int f);
    @(negedge clk); tick = 1'b1; acc_valid = 1'b1; acc_frame = IW'(f);
    @(negedge clk); tick = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic select(input int ef, input int ed, input int en, input string tag);
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    repeat (3) @(negedge clk);       // back-pressure: result must stay put
    chk(res_valid == 1'b1, {tag, " held"}, res_valid, 1);
    chk(res_frame == IW'(ef), {tag, " frame"}, res_frame, ef);
    chk(res_dirty == ed[0], {tag, " dirty"}, res_dirty, ed);
    chk(res_none == en[0], {tag, " none"}, res_none, en);
    res_ready = 1'b1;
    @(negedge clk); res_ready = 1'b0;
    chk(req_ready == 1'b1, "R9 idle after take", req_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);

    select(0, 0, 0, "R7 all zero lowest index");          // R1 histories zero

    for (int f = 0; f < 4; f++) touch(f);
    age(1);
    touch(4); touch(5);
    age(1);  // hist: 0..3=0x40, 4,5=0x80, 6,7=0
    select(6, 0, 0, "R5 smallest history");
    frame_dirty = 8'h40;
    select(7, 0, 0, "R6 clean preferred");
    frame_dirty = 8'hC0;
    select(6, 1, 0, "R10 dirty reported");
    frame_dirty = 8'h00; frame_lock = 8'hC0;
    select(0, 0, 0, "R8 pinned skipped");
    frame_lock = 8'hFF;
    select(0, 0, 1, "R8 all pinned");

    frame_lock = 8'h00;
    touch(7);
    age(1);  // 7 = 0x80, 6 = 0
    frame_lock = 8'h3F;
    select(6, 0, 0, "R2 access marks frame");

    age(7);  // 7 = 0x01, 6 = 0
    frame_dirty = 8'h40;
    select(6, 1, 0, "R3 low bit still held");
    age(1);  // 7 = 0
    select(7, 0, 0, "R3 oldest bit dropped");

    frame_dirty = 8'h00; frame_lock = 8'h00;
    age(2);
    age_with_touch(2);
    age(1);  // 2 = 0x80, 3 = 0
    frame_lock = 8'hF3;
    select(3, 0, 0, "R4 access with tick kept");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule